// File: doc/BRIEF.md
# Lagging Even-Parity Generator and Checker

This block looks after the single parity bit of a multiplexed 32-bit address/data bus and its 4-bit command/byte-enable field. Every clock it folds the 36 bus bits into one parity value. It registers that value so it appears on the parity pin exactly one clock after the bus value it covers. The agent that owns the phase drives the pin. Every other agent uses the same registered value as the expected parity and compares it against the bit it receives.

A small phase code tells the block what the bus carries on the current clock. The code can mean nothing, an address, write data or read data. The ready strobes tell the block whether the data on the bus is actually valid. An agent-role input says whether the local agent is the initiator or the target of the current transaction. From these inputs the block decides, one clock ahead, whether to drive the parity pin, to check it, or to ignore it.

Top module: `bus_parity_lag`

## Requirements
- R1: When `par_oe_o` is high, `par_o` plus the number of ones in `{cbe_n_i, ad_i}` sampled at the previous clock edge is even.
- R2: `phase_i` is decoded as 2'b00 = no phase, 2'b01 = address, 2'b10 = write data, 2'b11 = read data. A clock is a parity-bearing clock when it is an address clock, a write-data clock with `irdy_i` high, or a read-data clock with `trdy_i` high. Other clocks bear no parity.
- R3: `par_oe_o` is high in the cycle after a parity-bearing clock that this agent owns, and low otherwise. The agent owns address and write-data clocks when `am_master_i` is high, and read-data clocks when `am_master_i` is low.
- R4: `par_o` takes a new value only in the cycle after a parity-bearing clock. After any other clock it keeps its previous value. So a value stays on the pin through the clock that follows the completing data phase.
- R5: In the cycle after a parity-bearing clock that this agent does not own, `par_i` is compared with the expected parity. A mismatch raises `par_err_o` for one cycle, in the cycle that follows the comparison.
- R6: `par_err_o` stays low after any comparison cycle that does not follow an unowned parity-bearing clock, whatever `par_i` carries.
- R7: While `rst_n` is low, `par_o`, `par_oe_o` and `par_err_o` are low, without waiting for a clock edge. Reset release takes effect two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Address/data bus value seen this clock |
| cbe_n_i | input | 4 | Command/byte-enable field seen this clock |
| phase_i | input | 2 | Phase code for this clock (see R2) |
| am_master_i | input | 1 | 1 = local agent is initiator, 0 = target |
| irdy_i | input | 1 | Initiator ready, active high |
| trdy_i | input | 1 | Target ready, active high |
| par_i | input | 1 | Parity bit received from the bus |
| par_o | output | 1 | Generated parity bit, one clock late |
| par_oe_o | output | 1 | Drive enable for the parity pin |
| par_err_o | output | 1 | One-cycle pulse on a received parity mismatch |

## Verification
A fault in the registered parity value shows on `par_o` in the cycle after the parity-bearing clock it covers. A stale hold or a missed enable shows on the first idle or wait cycle that follows. A wrong ownership or check decision shows at the ports within one or two cycles. `par_oe_o` rises or fails to rise one cycle after the clock. A false or missing `par_err_o` pulse appears one cycle after that, so the bench injects corrupted parity on owned, unowned and idle clocks alike.

// File: rtl/bpl_pkg.sv
package bpl_pkg;

  // Phase code carried on phase_i
  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_ADDR  = 2'b01,
    PH_WDATA = 2'b10,
    PH_RDATA = 2'b11
  } phase_e;

  // Width of a pairwise XOR fold after lvl halvings of w inputs
  function automatic int fold_width(input int w, input int lvl);
    int r;
    r = w;
    for (int k = 0; k < lvl; k++) begin
      r = (r + 1) / 2;
    end
    return r;
  endfunction

endpackage

// File: rtl/bpl_rst_sync.sv
module bpl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  // Assert at once, release only after STAGES rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/bpl_xor_tree.sv
module bpl_xor_tree
  import bpl_pkg::*;
#(
  parameter int W = 36
) (
  input  logic [W-1:0] din,
  output logic         odd
);

  localparam int LV = (W <= 1) ? 0 : $clog2(W);

  // Balanced fold: each level halves the vector, an odd leftover passes through
  for (genvar l = 0; l <= LV; l++) begin : g_lvl
    localparam int WL = fold_width(W, l);
    logic [WL-1:0] v;
    if (l == 0) begin : g_leaf
      assign v = din;
    end else begin : g_fold
      localparam int PW = fold_width(W, l - 1);
      for (genvar i = 0; i < WL; i++) begin : g_node
        if (2 * i + 1 < PW) begin : g_pair
          assign v[i] = g_lvl[l-1].v[2*i] ^ g_lvl[l-1].v[2*i+1];
        end else begin : g_pass
          assign v[i] = g_lvl[l-1].v[2*i];
        end
      end
    end
  end

  assign odd = g_lvl[LV].v[0];

endmodule

// File: rtl/bpl_phase_dec.sv
module bpl_phase_dec
  import bpl_pkg::*;
(
  input  logic [1:0] phase_i,
  input  logic       am_master_i,
  input  logic       irdy_i,
  input  logic       trdy_i,
  output logic       qual_o,
  output logic       own_o
);

  phase_e ph;
  assign ph = phase_e'(phase_i);

  // qual_o: bus value on this clock carries parity next clock
  // own_o : the local agent is the one that drives that parity
  always_comb begin
    qual_o = 1'b0;
    own_o  = 1'b0;
    unique case (ph)
      PH_IDLE: begin
        qual_o = 1'b0;
        own_o  = 1'b0;
      end
      PH_ADDR: begin
        qual_o = 1'b1;
        own_o  = am_master_i;
      end
      PH_WDATA: begin
        qual_o = irdy_i;
        own_o  = irdy_i & am_master_i;
      end
      PH_RDATA: begin
        qual_o = trdy_i;
        own_o  = trdy_i & ~am_master_i;
      end
    endcase
  end

endmodule

// File: rtl/bus_parity_lag.sv
module bus_parity_lag
  import bpl_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_n_i,
  input  logic [1:0]      phase_i,
  input  logic            am_master_i,
  input  logic            irdy_i,
  input  logic            trdy_i,
  input  logic            par_i,
  output logic            par_o,
  output logic            par_oe_o,
  output logic            par_err_o
);

  localparam int COVER_W = AD_W + BE_W;

  logic rst_ni;
  logic qual, own, odd;
  logic par_q, par_d, par_en;
  logic oe_q, oe_d;
  logic chk_q, chk_d;
  logic err_q, err_d;

  bpl_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_no (rst_ni)
  );

  bpl_xor_tree #(.W(COVER_W)) u_tree (
    .din (({cbe_n_i, ad_i})),
    .odd (odd)
  );

  bpl_phase_dec u_dec (
    .phase_i     (phase_i),
    .am_master_i (am_master_i),
    .irdy_i      (irdy_i),
    .trdy_i      (trdy_i),
    .qual_o      (qual),
    .own_o       (own)
  );

  // Next-state logic
  always_comb begin
    par_en = qual;
    par_d  = odd;
    oe_d   = qual & own;
    chk_d  = qual & ~own;
    err_d  = chk_q & (par_i != par_q);
  end

  // Registers: parity value with explicit enable, flags every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
    end else if (!rst_ni) begin
      par_q <= 1'b0;
    end else if (par_en) begin
      par_q <= par_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      chk_q <= 1'b0;
      err_q <= 1'b0;
    end else if (!rst_ni) begin
      oe_q  <= 1'b0;
      chk_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      oe_q  <= oe_d;
      chk_q <= chk_d;
      err_q <= err_d;
    end
  end

  assign par_o     = par_q;
  assign par_oe_o  = oe_q;
  assign par_err_o = err_q;

  // R1: driven parity makes the covered bits plus itself even
  a_r1_even_total: assert property (@(posedge clk) disable iff (!rst_ni)
    par_oe_o |-> ((($countones({$past(cbe_n_i), $past(ad_i)}) + int'(par_o)) % 2) == 0));

  // R3: an owned parity-bearing clock enables the pin on the next cycle
  a_r3_owned_drives: assert property (@(posedge clk) disable iff (!rst_ni)
    (qual && own) |=> par_oe_o);

  // R3: no drive after a clock the agent does not own
  a_r3_no_foreign_drive: assert property (@(posedge clk) disable iff (!rst_ni)
    !(qual && own) |=> !par_oe_o);

  // R4: value holds across clocks that bear no parity
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !qual |=> $stable(par_o));

  // R5: an error pulse always traces back to a comparison cycle
  a_r5_err_cause: assert property (@(posedge clk) disable iff (!rst_ni)
    par_err_o |-> $past(chk_q));

  // R6: outside comparison cycles no error can follow
  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    !chk_q |=> !par_err_o);

  // R5: drive and compare never overlap
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({oe_q, chk_q}));

  // R7: reset forces the outputs low
  a_r7_reset_low: assert property (@(posedge clk)
    !rst_n |-> (!par_oe_o && !par_err_o && !par_o));

endmodule

// File: tb/bus_parity_lag_tb.sv
module bus_parity_lag_tb;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [31:0] ad;
  logic [3:0]  cbe;
  logic [1:0]  ph;
  logic        am, irdy, trdy, par_in;
  logic        par_o, par_oe, par_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // behavioural model state
  logic        m_par, m_oe, m_chk, m_err, m_err_src;
  logic [35:0] prev_bus;

  bus_parity_lag u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ad_i        (ad),
    .cbe_n_i     (cbe),
    .phase_i     (ph),
    .am_master_i (am),
    .irdy_i      (irdy),
    .trdy_i      (trdy),
    .par_i       (par_in),
    .par_o       (par_o),
    .par_oe_o    (par_oe),
    .par_err_o   (par_err)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2 R3 par_oe", par_oe, m_oe);
    chk("R1 R4 par_o", par_o, m_par);
    if (m_err_src) chk("R5 par_err", par_err, m_err);
    else           chk("R6 par_err", par_err, m_err);
  endtask

  task automatic model_clear();
    m_par = 1'b0; m_oe = 1'b0; m_chk = 1'b0; m_err = 1'b0; m_err_src = 1'b0;
  endtask

  // One bus clock: check what the last edge produced, then drive the next one
  task automatic step(input logic [1:0] p, input logic m, input logic i,
                      input logic t, input logic [31:0] a, input logic [3:0] c,
                      input logic corrupt);
    logic q, o, n_err;
    @(negedge clk);
    compare();
    ph = p; am = m; irdy = i; trdy = t; ad = a; cbe = c;
    par_in = 1'($countones(prev_bus) % 2) ^ corrupt;
    q = (p == 2'b01) || (p == 2'b10 && i) || (p == 2'b11 && t);
    o = (p == 2'b11) ? !m : m;
    n_err     = m_chk && (par_in != m_par);
    m_err_src = m_chk;
    if (q) m_par = 1'($countones({c, a}) % 2);
    m_oe  = q && o;
    m_chk = q && !o;
    m_err = n_err;
    prev_bus = {c, a};
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(2'b00, 1'b0, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; ad = '0; cbe = '0; ph = 2'b00; am = 1'b0;
    irdy = 1'b0; trdy = 1'b0; par_in = 1'b0; prev_bus = '0;
    model_clear();
    repeat (3) @(negedge clk);
    // R7: outputs low while held in reset
    chk("R7 par_oe in reset", par_oe, 1'b0);
    chk("R7 par_err in reset", par_err, 1'b0);
    chk("R7 par_o in reset", par_o, 1'b0);
    rst_n = 1'b1;
    idle(4);

    // Initiator write: address, wait, data with irdy, completion, then hold check
    step(2'b01, 1, 0, 0, 32'h1234_5678, 4'h7, 0);
    step(2'b10, 1, 0, 0, 32'hFFFF_0000, 4'hE, 0);
    step(2'b10, 1, 1, 0, 32'hA5A5_A5A4, 4'h0, 0);
    step(2'b10, 1, 1, 1, 32'hA5A5_A5A4, 4'h0, 0);
    step(2'b10, 1, 1, 1, 32'h0000_0001, 4'h3, 0);
    idle(3);

    // Initiator read: target drives parity, good then corrupted, then idle junk
    step(2'b01, 1, 0, 0, 32'h8000_0000, 4'h6, 1);
    step(2'b11, 1, 1, 0, 32'h0F0F_0F0F, 4'h0, 1);
    step(2'b11, 1, 1, 1, 32'h1111_1111, 4'h0, 1);
    step(2'b11, 1, 1, 1, 32'h2222_2223, 4'h1, 0);
    step(2'b11, 1, 1, 1, 32'h3333_3333, 4'h0, 1);
    step(2'b00, 1, 0, 0, 32'h0, 4'h0, 1);
    step(2'b00, 1, 0, 0, 32'h0, 4'h0, 1);
    idle(2);

    // Target role: receive address and write data, drive read data
    step(2'b01, 0, 0, 0, 32'hDEAD_BEEF, 4'hA, 0);
    step(2'b10, 0, 1, 1, 32'hCAFE_F00D, 4'h0, 1);
    step(2'b10, 0, 1, 1, 32'h0000_0000, 4'hF, 1);
    step(2'b11, 0, 1, 0, 32'h7777_7777, 4'h0, 1);
    step(2'b11, 0, 1, 1, 32'h7777_7776, 4'h0, 1);
    step(2'b11, 0, 1, 1, 32'h0101_0101, 4'h5, 0);
    idle(3);

    // Random traffic with random corruption
    for (int k = 0; k < 3000; k++) begin
      step(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           32'($urandom), 4'($urandom), 1'($urandom));
    end

    // Mid-run asynchronous reset while driving an owned phase
    step(2'b01, 1, 0, 0, 32'h0000_0007, 4'h0, 0);
    step(2'b10, 1, 1, 0, 32'h0000_0003, 4'h1, 0);
    @(negedge clk);
    compare();
    #4 rst_n = 1'b0;
    #1;
    chk("R7 par_oe async", par_oe, 1'b0);
    chk("R7 par_err async", par_err, 1'b0);
    chk("R7 par_o async", par_o, 1'b0);
    ph = 2'b00; irdy = 1'b0; trdy = 1'b0; am = 1'b0; par_in = 1'b1;
    ad = '0; cbe = '0; prev_bus = '0;
    model_clear();
    idle(3);
    rst_n = 1'b1;
    idle(4);
    step(2'b01, 1, 0, 0, 32'h0000_00FF, 4'h1, 0);
    idle(2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule